// File: doc/BRIEF.md
# Constant Off-Time PWM Sequencer

This block sequences the gate drive of a peak-current-mode converter that runs with a fixed off time instead of a fixed switching frequency. Each pulse is ended by a current comparator once its blanking window has passed. It can also be ended sooner by an overcurrent comparator, which has its own shorter blanking window. If neither comparator fires, the pulse is ended by force at a maximum on time. When a pulse ends, a timer runs for a programmable number of clocks, and the next pulse starts as soon as that timer expires. The switching period therefore follows from the on time that the current loop sets, plus the programmed off time.

Both comparators reach the block as digital flags. The off time and the two blanking windows are clock counts given on input buses, and the maximum on time is a parameter. When a switching cycle ends, the block raises one strobe for one clock. The strobe tells the fault-tracking logic next to it why the pulse ended: peak reached, time limit, or overcurrent. When the enable input is low, the drive is held low, and the off timer restarts once enable returns.

Top module: `cot_pwm_seq`

## Requirements
- R1: While `rst` is high, `drv_o` and all three strobes are low. When reset is released with `en_i` high, `drv_o` stays low for exactly L clocks, counted from the cycle of release, and then rises. L is `off_cnt_i`, or 1 when `off_cnt_i` is 0.
- R2: After every falling edge of `drv_o`, the drive stays low for exactly L clocks before it rises again.
- R3: Number the clocks of a pulse from 0. The pulse ends after clock k, so the drive is high for k+1 clocks, where k is the first clock with `cmp_peak_i` high and k ≥ max(`blank_cnt_i`,1)−1.
- R4: A high `cmp_peak_i` during the first max(`blank_cnt_i`,1)−1 clocks of a pulse is ignored. A flag that stays high for the whole pulse therefore gives a minimum on time of max(`blank_cnt_i`,1) clocks.
- R5: The overcurrent flag ends a pulse in the same way, using its own window `ocp_blank_cnt_i`, and raises `ev_ocp_o`.
- R6: If no comparator ends a pulse, the drive stays high for exactly TON_MAX clocks, and `ev_tmax_o` is raised.
- R7: If both flags qualify in the same clock, the overcurrent cause wins.
- R8: If `en_i` is low at a clock edge, `drv_o` is low after that edge. A pulse cut short this way raises no strobe, and the off timer starts again from zero when enable returns.
- R9: Every pulse that ends by a comparator or by the time limit raises exactly one strobe, for one clock, in the first clock in which the drive is low. The strobe is `ev_peak_o` for the peak cause (code 1 in {ocp,tmax,peak}), `ev_tmax_o` for the time limit (code 2) and `ev_ocp_o` for overcurrent (code 4).
- R10: An `off_cnt_i` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Switching enable; low holds the drive off |
| cmp_peak_i | input | 1 | Current comparator flag |
| cmp_ocp_i | input | 1 | Overcurrent comparator flag |
| off_cnt_i | input | OFF_W | Off time in clocks |
| blank_cnt_i | input | BLK_W | Current comparator blanking in clocks |
| ocp_blank_cnt_i | input | BLK_W | Overcurrent comparator blanking in clocks |
| drv_o | output | 1 | Gate drive |
| ev_peak_o | output | 1 | Pulse ended by peak current |
| ev_tmax_o | output | 1 | Pulse ended by maximum on time |
| ev_ocp_o | output | 1 | Pulse ended by overcurrent |

## Verification
A shared phase counter that is off by one shows at the ports as a pulse width or an off time one clock off from the expected value, inside the very first switching cycle after reset. A wrong cause priority or a wrong blanking comparison shows in the same cycle: the strobe code or the pulse length is wrong at the first low clock after the drive falls. A phase state that does not clear on disable shows one clock after `en_i` falls, as a drive still high or as a strobe that should not be there.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_e;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PEAK = 2'd1,
    CAUSE_TMAX = 2'd2,
    CAUSE_OCP  = 2'd3
  } cause_e;
  localparam int N_CAUSE = 3;
endpackage

// File: rtl/cot_phase_timer.sv
// Counts clocks spent in the current phase; cleared at every phase change.
module cot_phase_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cot_off_expiry.sv
// Flags the last clock of the off phase; a zero length counts as one.
module cot_off_expiry #(
  parameter int CNT_W = 13,
  parameter int OFF_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [OFF_W-1:0] off_cnt,
  output logic             expire
);
  logic [CNT_W:0] next_cnt;
  logic [CNT_W:0] len;

  always_comb begin
    next_cnt = {1'b0, cnt} + 1'b1;
    len      = {{(CNT_W+1-OFF_W){1'b0}}, off_cnt};
    if (len == '0) len = {{CNT_W{1'b0}}, 1'b1};
    expire = (next_cnt >= len);
  end
endmodule

// File: rtl/cot_term_arbiter.sv
// Decides whether the on phase ends in this clock, and why.
module cot_term_arbiter
  import cot_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int BLK_W   = 8,
  parameter int TON_MAX = 3400
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [BLK_W-1:0] blank,
  input  logic [BLK_W-1:0] ocp_blank,
  input  logic             en,
  input  logic             cmp_peak,
  input  logic             cmp_ocp,
  output logic             stop,
  output cause_e           cause
);
  localparam logic [CNT_W:0] TMAX_V = (CNT_W+1)'(TON_MAX);

  logic [CNT_W:0] next_cnt;
  logic           peak_open;
  logic           ocp_open;
  logic           tmax_hit;

  always_comb begin
    next_cnt  = {1'b0, cnt} + 1'b1;
    peak_open = next_cnt >= {{(CNT_W+1-BLK_W){1'b0}}, blank};
    ocp_open  = next_cnt >= {{(CNT_W+1-BLK_W){1'b0}}, ocp_blank};
    tmax_hit  = next_cnt >= TMAX_V;
    stop      = 1'b1;
    cause     = CAUSE_NONE;
    if (!en)                        cause = CAUSE_NONE;
    else if (cmp_ocp && ocp_open)   cause = CAUSE_OCP;
    else if (cmp_peak && peak_open) cause = CAUSE_PEAK;
    else if (tmax_hit)              cause = CAUSE_TMAX;
    else                            stop  = 1'b0;
  end
endmodule

// File: rtl/cot_pwm_seq.sv
module cot_pwm_seq
  import cot_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int BLK_W   = 8,
  parameter int TON_MAX = 3400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             cmp_peak_i,
  input  logic             cmp_ocp_i,
  input  logic [OFF_W-1:0] off_cnt_i,
  input  logic [BLK_W-1:0] blank_cnt_i,
  input  logic [BLK_W-1:0] ocp_blank_cnt_i,
  output logic             drv_o,
  output logic             ev_peak_o,
  output logic             ev_tmax_o,
  output logic             ev_ocp_o
);
  localparam int TW    = $clog2(TON_MAX + 1);
  localparam int BASEW = (TW > OFF_W) ? TW : OFF_W;
  localparam int CNT_W = ((BASEW > BLK_W) ? BASEW : BLK_W) + 1;

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt;
  logic               off_done;
  logic               on_stop;
  cause_e             on_cause;
  logic               clr;
  logic               fire;
  logic [N_CAUSE-1:0] ev_q;

  cot_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .cnt(cnt)
  );

  cot_off_expiry #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_off (
    .cnt(cnt), .off_cnt(off_cnt_i), .expire(off_done)
  );

  cot_term_arbiter #(.CNT_W(CNT_W), .BLK_W(BLK_W), .TON_MAX(TON_MAX)) u_arb (
    .cnt(cnt), .blank(blank_cnt_i), .ocp_blank(ocp_blank_cnt_i),
    .en(en_i), .cmp_peak(cmp_peak_i), .cmp_ocp(cmp_ocp_i),
    .stop(on_stop), .cause(on_cause)
  );

  always_comb begin
    if (ph_q == PH_OFF) clr = !en_i || off_done;
    else                clr = on_stop;
    fire = (ph_q == PH_ON) && on_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_OFF;
    else begin
      case (ph_q)
        PH_OFF:  if (en_i && off_done) ph_q <= PH_ON;
        default: if (on_stop)          ph_q <= PH_OFF;
      endcase
    end
  end

  // One strobe register per cause; cause code g+1 drives bit g.
  for (genvar g = 0; g < N_CAUSE; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst) ev_q[g] <= 1'b0;
      else     ev_q[g] <= fire && (on_cause == cause_e'(g + 1));
    end
  end

  assign drv_o     = (ph_q == PH_ON);
  assign ev_peak_o = ev_q[0];
  assign ev_tmax_o = ev_q[1];
  assign ev_ocp_o  = ev_q[2];
endmodule

// File: rtl/cot_pwm_seq_chk.sv
module cot_pwm_seq_chk #(
  parameter int TON_MAX = 3400
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic cmp_peak_i,
  input logic cmp_ocp_i,
  input logic drv_o,
  input logic ev_peak_o,
  input logic ev_tmax_o,
  input logic ev_ocp_o
);
  localparam int HW = $clog2(TON_MAX + 2) + 1;
  logic [HW-1:0] hi_run;
  logic          any_ev;

  assign any_ev = ev_peak_o || ev_tmax_o || ev_ocp_o;

  always_ff @(posedge clk) begin
    if (rst)        hi_run <= '0;
    else if (drv_o) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!drv_o && !any_ev));

  p_en_cut_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!drv_o && !any_ev));

  p_one_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_ocp_o, ev_tmax_o, ev_peak_o}));

  p_ev_after_fall_r9: assert property (@(posedge clk) disable iff (rst)
    any_ev |-> (!drv_o && $past(drv_o)));

  p_peak_flag_r3: assert property (@(posedge clk) disable iff (rst)
    ev_peak_o |-> $past(cmp_peak_i));

  p_ocp_flag_r5: assert property (@(posedge clk) disable iff (rst)
    ev_ocp_o |-> $past(cmp_ocp_i));

  p_on_limit_r6: assert property (@(posedge clk) disable iff (rst)
    drv_o |-> (hi_run < HW'(TON_MAX)));

  p_tmax_len_r6: assert property (@(posedge clk) disable iff (rst)
    ev_tmax_o |-> (hi_run == HW'(TON_MAX)));
endmodule

bind cot_pwm_seq cot_pwm_seq_chk #(.TON_MAX(TON_MAX)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .cmp_peak_i(cmp_peak_i),
  .cmp_ocp_i(cmp_ocp_i), .drv_o(drv_o), .ev_peak_o(ev_peak_o),
  .ev_tmax_o(ev_tmax_o), .ev_ocp_o(ev_ocp_o)
);

// File: tb/cot_pwm_seq_bench.sv
module cot_pwm_seq_bench;
  localparam int OFF_W   = 12;
  localparam int BLK_W   = 8;
  localparam int TON_MAX = 3400;
  localparam int NEVER   = 100000;
  localparam int NV      = 9;
  localparam int LIMIT   = 20000;

  // columns: off, blank, ocp_blank, peak flag from clock, ocp flag from clock
  localparam int VEC [NV][5] = '{
    '{10,   8, 3, 20,    NEVER},  // R3 peak after blanking
    '{1,    8, 3, 0,     NEVER},  // R4 minimum on time
    '{0,    8, 3, 0,     NEVER},  // R10 zero off count
    '{25,   8, 3, NEVER, NEVER},  // R6 time limit
    '{5,   10, 4, NEVER, 0},      // R5 overcurrent window
    '{5,   10, 4, 6,     6},      // R5 overcurrent before peak window
    '{7,    4, 4, 5,     5},      // R7 same clock, overcurrent wins
    '{3,    0, 0, 0,     NEVER},  // R4 zero blanking, one clock
    '{1100, 30, 12, 40,  NEVER}   // R2 long off time
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0;
  logic cmp_peak_i = 1'b0;
  logic cmp_ocp_i = 1'b0;
  logic [OFF_W-1:0] off_cnt_i = '0;
  logic [BLK_W-1:0] blank_cnt_i = '0;
  logic [BLK_W-1:0] ocp_blank_cnt_i = '0;
  logic drv_o, ev_peak_o, ev_tmax_o, ev_ocp_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  cot_pwm_seq #(.OFF_W(OFF_W), .BLK_W(BLK_W), .TON_MAX(TON_MAX)) u_cot_pwm_seq (
    .clk(clk), .rst(rst), .en_i(en_i), .cmp_peak_i(cmp_peak_i),
    .cmp_ocp_i(cmp_ocp_i), .off_cnt_i(off_cnt_i), .blank_cnt_i(blank_cnt_i),
    .ocp_blank_cnt_i(ocp_blank_cnt_i), .drv_o(drv_o), .ev_peak_o(ev_peak_o),
    .ev_tmax_o(ev_tmax_o), .ev_ocp_o(ev_ocp_o)
  );

  function automatic int evcode();
    return (ev_ocp_o ? 4 : 0) + (ev_tmax_o ? 2 : 0) + (ev_peak_o ? 1 : 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge where the drive is low; returns low clocks including this one.
  task automatic count_low(output int lo, output int extra_ev);
    lo = 1;
    extra_ev = 0;
    forever begin
      @(negedge clk);
      if (drv_o || lo > LIMIT) break;
      if (evcode() != 0) extra_ev++;
      lo++;
    end
  endtask

  task automatic run_vec(int off, int blk, int oblk, int pk, int oc);
    int len, ip, io, m, exp_cause, lo, k, xev;
    string tag;
    len = (off < 1) ? 1 : off;
    ip = (blk < 1) ? 0 : blk - 1;  if (pk > ip) ip = pk;
    io = (oblk < 1) ? 0 : oblk - 1; if (oc > io) io = oc;
    m = TON_MAX - 1;
    if (ip < m) m = ip;
    if (io < m) m = io;
    exp_cause = (io == m) ? 4 : ((ip == m) ? 1 : 2);
    tag = (exp_cause == 4) ? "R5/R7" : ((exp_cause == 1) ? "R3/R4" : "R6");

    @(negedge clk);
    rst = 1'b1; en_i = 1'b1; cmp_peak_i = 1'b0; cmp_ocp_i = 1'b0;
    off_cnt_i = OFF_W'(off); blank_cnt_i = BLK_W'(blk); ocp_blank_cnt_i = BLK_W'(oblk);
    @(negedge clk);
    chk("R1 drive in reset", int'(drv_o), 0);
    chk("R1 strobes in reset", evcode(), 0);
    rst = 1'b0;
    count_low(lo, xev);
    chk((off == 0) ? "R10 first off" : "R1 first off", lo, len);

    k = 0;
    cmp_peak_i = (k >= pk); cmp_ocp_i = (k >= oc);
    forever begin
      @(negedge clk);
      if (!drv_o || k > LIMIT) break;
      k++;
      cmp_peak_i = (k >= pk); cmp_ocp_i = (k >= oc);
    end
    chk({tag, " on clocks"}, k + 1, m + 1);
    chk({"R9 cause ", tag}, evcode(), exp_cause);
    cmp_peak_i = 1'b0; cmp_ocp_i = 1'b0;
    count_low(lo, xev);
    chk((off == 0) ? "R10 off time" : "R2 off time", lo, len);
    chk("R9 single strobe", xev, 0);
  endtask

  task automatic wait_high();
    int n;
    n = 0;
    while (!drv_o && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int lo, xev, highs;
    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

    // R8: enable dropped during a pulse
    run_vec(6, 5, 2, NEVER, NEVER);
    wait_high();
    @(negedge clk); @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R8 drive after disable", int'(drv_o), 0);
    chk("R8 no strobe on disable", evcode(), 0);
    highs = 0; xev = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (drv_o) highs++;
      if (evcode() != 0) xev++;
    end
    chk("R8 held low", highs, 0);
    chk("R8 no strobes while off", xev, 0);
    en_i = 1'b1;
    count_low(lo, xev);
    chk("R8 off timer restart", lo, 6);

    // R1: reset during a pulse
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid pulse drive", int'(drv_o), 0);
    chk("R1 reset mid pulse strobe", evcode(), 0);
    rst = 1'b0;
    count_low(lo, xev);
    chk("R1 restart after reset", lo, 6);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule